// File: doc/BRIEF.md
# Master Serial Configuration Loader

This block sits in a device that configures itself from an external serial memory. After power-up, or after a low pulse on the program input, it first holds the open-drain INIT line low while the internal configuration store is cleared. It then lets INIT go and waits until INIT is seen high. Once INIT is high it drives a configuration clock to the memory and takes in one data bit on every rising edge of that clock. It packs the bits into bytes, most significant bit first, and hands each byte to a downstream consumer with a one-cycle strobe.

The configuration clock has two rates. The divider produces a fast clock, nominally 10 MHz, or a slow clock, nominally 1.25 MHz, which is chosen when the rate-select input is high. The DONE pin stays low for as long as the load runs, and that low level enables the serial memory. After the last bit the clock stops and a start-up phase follows. DONE rises at the end of start-up, or at its beginning if the early-release option is set, so the shared data pin is released sooner. A program pulse aborts a load in progress at any point and restarts the whole sequence.

The controller has five named states:
- `ST_CLEAR` holds INIT low and counts the clearing time.
- `ST_WAIT_INIT` waits for INIT to read high.
- `ST_LOAD` runs the configuration clock.
- `ST_STARTUP` counts the start-up cycles.
- `ST_DONE` is the final state and holds.

The transitions are:
- CLEAR goes to WAIT_INIT when the clear count expires and the program input reads high.
- WAIT_INIT goes to LOAD when the synchronised INIT reads high.
- LOAD goes to STARTUP on the last bit.
- STARTUP goes to DONE when its count expires.
- A falling edge of the synchronised program input goes from any state back to CLEAR.

Top module: `msc_loader`

## Requirements
- R1: While reset is asserted, `init_low` is 1 and `cclk`, `done` and `load_done` are 0. After reset is released, `init_low` stays 1 for exactly CLEAR_CYCLES clocks.
- R2: After clearing, `init_low` is released. `cclk` stays low, with no edges, for as long as `init_in` is held low by the outside.
- R3: Each half period of `cclk` during a load lasts FAST_HALF system clocks when `slow_sel` was 0, or SLOW_HALF clocks when it was 1. The rate is sampled while the clock is idle, so changing `slow_sel` during a load has no effect on that load.
- R4: On each rising edge of `cclk`, `din` is captured as one bit. Bytes are built most significant bit first: the first bit of each byte lands in `byte_data[7]`. `byte_valid` pulses for one clock once each group of 8 bits is complete.
- R5: After LOAD_BITS rising edges, `cclk` stops low and makes no further edges. Exactly LOAD_BITS/8 bytes are delivered.
- R6: `done` is 0 from reset until the load is complete. With `early_done` = 0, `done` and `load_done` rise in the same cycle, STARTUP_CYCLES clocks after the last bit. After that both stay high.
- R7: With `early_done` = 1, `done` rises when start-up begins, which is STARTUP_CYCLES clocks before `load_done` rises.
- R8: A falling edge of `prog_n` seen in any state raises `init_low` within 4 clocks and drops `done` and `load_done`. Clearing holds for as long as `prog_n` is low. It then lasts CLEAR_CYCLES clocks after the synchronised release.
- R9: A program pulse during a load aborts that load. The next load counts its bits from zero and delivers a complete, correctly aligned set of bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-up reset, active low |
| prog_n | input | 1 | Asynchronous program request, active low |
| slow_sel | input | 1 | 1 selects the slow configuration clock rate |
| early_done | input | 1 | 1 raises DONE at the start of start-up |
| init_in | input | 1 | Sensed level of the INIT line |
| din | input | 1 | Serial data from the memory |
| cclk | output | 1 | Configuration clock to the memory |
| init_low | output | 1 | Drives the INIT line low while clearing |
| done | output | 1 | DONE pin; its low level enables the memory |
| byte_data | output | 8 | Assembled configuration byte |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| load_done | output | 1 | Load and start-up complete |

## Verification
The bench builds the block with FAST_HALF=2, SLOW_HALF=5, LOAD_BITS=32, CLEAR_CYCLES=6 and STARTUP_CYCLES=4. With these values a complete load takes a few hundred cycles, so many loads fit in one run: back-to-back loads at both rates, with and without early DONE, with rate flips during a load, and with aborts. Because the two half periods are unequal and small, a wrong divider choice shows up on every cycle. A 32-bit load spans four bytes, so byte alignment after an aborted load can be checked directly.

// File: rtl/msc_pkg.sv
package msc_pkg;

    typedef enum logic [2:0] {
        ST_CLEAR     = 3'd0,
        ST_WAIT_INIT = 3'd1,
        ST_LOAD      = 3'd2,
        ST_STARTUP   = 3'd3,
        ST_DONE      = 3'd4
    } ld_state_t;

endpackage

// File: rtl/msc_sync.sv
module msc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/msc_clkgen.sv
module msc_clkgen #(
    parameter int FAST_HALF = 4,
    parameter int SLOW_HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic slow_req,
    output logic cclk,
    output logic rise
);
    localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int CW   = $clog2(MAXH + 1);

    logic          slow_q;
    logic          cclk_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] half_m1;
    logic          wrap;

    // rate frozen while the clock runs
    always_comb begin
        half_m1 = slow_q ? CW'(SLOW_HALF - 1) : CW'(FAST_HALF - 1);
    end

    assign wrap = (cnt == half_m1);
    assign rise = en && wrap && !cclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            cclk_q <= 1'b0;
            slow_q <= 1'b0;
        end else if (!en) begin
            cnt    <= '0;
            cclk_q <= 1'b0;
            slow_q <= slow_req;
        end else if (wrap) begin
            cnt    <= '0;
            cclk_q <= ~cclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    assign cclk = cclk_q;
endmodule

// File: rtl/msc_shifter.sv
module msc_shifter #(
    parameter int LOAD_BITS = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       sample,
    input  logic       din,
    output logic [7:0] byte_data,
    output logic       byte_valid,
    output logic       last_bit
);
    localparam int BW = $clog2(LOAD_BITS + 1);

    logic [6:0]    part;
    logic [2:0]    pos;
    logic [BW-1:0] nbits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part       <= '0;
            pos        <= '0;
            nbits      <= '0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
            last_bit   <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            last_bit   <= 1'b0;
            if (clr) begin
                part  <= '0;
                pos   <= '0;
                nbits <= '0;
            end else if (sample) begin
                part  <= {part[5:0], din};
                pos   <= pos + 1'b1;
                nbits <= nbits + 1'b1;
                if (pos == 3'd7) begin
                    byte_data  <= {part, din};
                    byte_valid <= 1'b1;
                end
                if (nbits == BW'(LOAD_BITS - 1)) begin
                    last_bit <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/msc_loader.sv
module msc_loader
    import msc_pkg::*;
#(
    parameter int FAST_HALF      = 4,
    parameter int SLOW_HALF      = 32,
    parameter int LOAD_BITS      = 4096,
    parameter int CLEAR_CYCLES   = 256,
    parameter int STARTUP_CYCLES = 16,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_n,
    input  logic       slow_sel,
    input  logic       early_done,
    input  logic       init_in,
    input  logic       din,
    output logic       cclk,
    output logic       init_low,
    output logic       done,
    output logic [7:0] byte_data,
    output logic       byte_valid,
    output logic       load_done
);
    localparam int CCW = $clog2(CLEAR_CYCLES + 1);
    localparam int SCW = $clog2(STARTUP_CYCLES + 1);

    ld_state_t      state;
    ld_state_t      nxt;
    logic [CCW-1:0] clr_cnt;
    logic [SCW-1:0] su_cnt;

    logic prog_s;
    logic prog_prev;
    logic prog_fall;
    logic init_s;
    logic slow_s;
    logic clk_en;
    logic shift_clr;
    logic rise;
    logic last_bit;

    msc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_prog (
        .clk(clk), .rst_n(rst_n), .d(prog_n), .q(prog_s)
    );
    msc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_init (
        .clk(clk), .rst_n(rst_n), .d(init_in), .q(init_s)
    );
    msc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_rate (
        .clk(clk), .rst_n(rst_n), .d(slow_sel), .q(slow_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_prev <= 1'b1;
        end else begin
            prog_prev <= prog_s;
        end
    end

    assign prog_fall = prog_prev && !prog_s;

    msc_clkgen #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .en(clk_en), .slow_req(slow_s),
        .cclk(cclk), .rise(rise)
    );

    msc_shifter #(.LOAD_BITS(LOAD_BITS)) u_shifter (
        .clk(clk), .rst_n(rst_n), .clr(shift_clr), .sample(rise), .din(din),
        .byte_data(byte_data), .byte_valid(byte_valid), .last_bit(last_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLEAR;
        end else begin
            state <= nxt;
        end
    end

    // phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_cnt <= '0;
            su_cnt  <= '0;
        end else begin
            if (state != ST_CLEAR || !prog_s) begin
                clr_cnt <= '0;
            end else begin
                clr_cnt <= clr_cnt + 1'b1;
            end
            if (state != ST_STARTUP) begin
                su_cnt <= '0;
            end else begin
                su_cnt <= su_cnt + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (prog_fall) begin
            nxt = ST_CLEAR;
        end else begin
            unique case (state)
                ST_CLEAR: begin
                    if (prog_s && clr_cnt == CCW'(CLEAR_CYCLES - 1)) begin
                        nxt = ST_WAIT_INIT;
                    end
                end
                ST_WAIT_INIT: begin
                    if (init_s) begin
                        nxt = ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (last_bit) begin
                        nxt = ST_STARTUP;
                    end
                end
                ST_STARTUP: begin
                    if (su_cnt == SCW'(STARTUP_CYCLES - 1)) begin
                        nxt = ST_DONE;
                    end
                end
                ST_DONE: nxt = ST_DONE;
                default: nxt = ST_CLEAR;
            endcase
        end
    end

    // outputs
    always_comb begin
        init_low  = 1'b0;
        done      = 1'b0;
        load_done = 1'b0;
        clk_en    = 1'b0;
        shift_clr = 1'b0;
        unique case (state)
            ST_CLEAR: begin
                init_low  = 1'b1;
                shift_clr = 1'b1;
            end
            ST_WAIT_INIT: begin
                shift_clr = 1'b0;
            end
            ST_LOAD: begin
                clk_en = 1'b1;
            end
            ST_STARTUP: begin
                done = early_done;
            end
            ST_DONE: begin
                done      = 1'b1;
                load_done = 1'b1;
            end
            default: begin
                init_low  = 1'b1;
                shift_clr = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/msc_loader_chk.sv
module msc_loader_chk
    import msc_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cclk,
    input logic      init_low,
    input logic      done,
    input logic      load_done,
    input logic      byte_valid,
    input ld_state_t state
);
    AST_CLEAR_CCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (init_low && $past(init_low)) |-> !cclk); // R1

    AST_WAIT_CCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_INIT) |-> !cclk); // R2

    AST_RISE_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk) |-> ($past(state) == ST_LOAD)); // R3

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid); // R4

    AST_STOPPED_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> !cclk); // R5

    AST_DONE_LOW_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> !done); // R6

    AST_FLAG_IMPLIES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> done); // R6

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> (load_done || init_low)); // R8
endmodule

bind msc_loader msc_loader_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cclk(cclk), .init_low(init_low),
    .done(done), .load_done(load_done), .byte_valid(byte_valid), .state(state)
);

// File: tb/tb_msc_loader.sv
module tb_msc_loader;
    localparam int FH = 2;
    localparam int SH = 5;
    localparam int LB = 32;
    localparam int CC = 6;
    localparam int SC = 4;
    localparam int NB = LB / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_n = 1'b1;
    logic slow_sel = 1'b0;
    logic early_done = 1'b0;
    logic hold = 1'b0;
    logic init_in;
    logic din;
    logic cclk, init_low, done, byte_valid, load_done;
    logic [7:0] byte_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] pat [NB];
    int got [16];
    int got_n, rises, idx, run, gap, exp_h;
    logic prev_c, done_in_load;

    always #4 clk = ~clk;

    assign init_in = ~(init_low | hold);
    assign din = (idx < LB) ? pat[idx / 8][7 - (idx % 8)] : 1'b0;

    msc_loader #(.FAST_HALF(FH), .SLOW_HALF(SH), .LOAD_BITS(LB),
                 .CLEAR_CYCLES(CC), .STARTUP_CYCLES(SC), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .slow_sel(slow_sel),
        .early_done(early_done), .init_in(init_in), .din(din), .cclk(cclk),
        .init_low(init_low), .done(done), .byte_data(byte_data),
        .byte_valid(byte_valid), .load_done(load_done)
    );

    function automatic int half_of(input logic s);
        return s ? SH : FH;
    endfunction

    function automatic int gap_of(input logic e);
        return e ? SC : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // memory model and observers
    initial begin
        got_n = 0; rises = 0; idx = 0; run = 0; gap = 0; exp_h = FH;
        prev_c = 1'b0; done_in_load = 1'b0;
        forever begin
            @(negedge clk);
            if (init_low) begin
                got_n = 0; rises = 0; idx = 0; run = 0; gap = 0;
                prev_c = 1'b0; done_in_load = 1'b0;
            end else begin
                if (byte_valid) begin
                    if (got_n < 16) got[got_n] = int'(byte_data);
                    got_n++;
                end
                if (done && !load_done) gap++;
                if (done && !load_done && rises > 0 && rises < LB) done_in_load = 1'b1;
                if (cclk != prev_c) begin
                    if (prev_c && rises < LB)
                        chk(run == exp_h, "R3 high half period", run, exp_h);
                    if (!prev_c && rises > 0)
                        chk(run == exp_h, "R3 low half period", run, exp_h);
                    if (cclk) begin
                        rises++;
                        idx++;
                    end
                    run = 1;
                end else begin
                    run++;
                end
                prev_c = cclk;
            end
        end
    end

    task automatic fill_pat();
        for (int k = 0; k < NB; k++) pat[k] = 8'($urandom);
    endtask

    task automatic pulse_prog(input int low_cycles);
        int w;
        prog_n = 1'b0;
        w = 0;
        while (!init_low && w < 4) begin
            @(negedge clk);
            w++;
        end
        chk(init_low == 1'b1, "R8 init_low after program edge", int'(init_low), 1);
        chk(!done && !load_done, "R8 done dropped", int'(done), 0);
        fill_pat();
        repeat (low_cycles) @(negedge clk);
        chk(init_low && !cclk, "R8 held in clear while program low", int'(init_low), 1);
        prog_n = 1'b1;
        w = 0;
        while (init_low && w < 100) begin
            w++;
            @(negedge clk);
        end
        chk(w >= CC && w <= CC + 3, "R8 clear length after release", w, CC);
    endtask

    task automatic finish_load(input logic flip);
        int t = 0;
        bit flipped = 0;
        while (!load_done && t < 5000) begin
            @(negedge clk);
            t++;
            if (flip && !flipped && rises == 4) begin
                slow_sel = ~slow_sel;   // R3: change mid-load must be ignored
                flipped = 1;
            end
        end
        chk(load_done == 1'b1, "R6 load completed", int'(load_done), 1);
        chk(rises == LB, "R5 rising edge count", rises, LB);
        chk(got_n == NB, "R4 byte count", got_n, NB);
        for (int k = 0; k < NB; k++)
            chk(got[k] == int'(pat[k]), "R4 byte value msb first", got[k], int'(pat[k]));
        chk(gap == gap_of(early_done), early_done ? "R7 early done lead" : "R6 done with flag",
            gap, gap_of(early_done));
        chk(!done_in_load, "R6 done low while loading", int'(done_in_load), 0);
        repeat (40) @(negedge clk);
        chk(rises == LB && !cclk, "R5 clock stopped after load", rises, LB);
        chk(done && load_done, "R6 done stays high", int'(done), 1);
    endtask

    task automatic run_load(input logic s, input logic e, input logic flip);
        slow_sel = s;
        early_done = e;
        exp_h = half_of(s);
        repeat (4) @(negedge clk);
        pulse_prog(8);
        finish_load(flip);
    endtask

    initial begin
        void'($urandom(32'd4711));
        fill_pat();
        hold = 1'b1;
        repeat (5) @(negedge clk);
        chk(init_low && !cclk && !done && !load_done, "R1 reset state",
            int'({init_low, cclk, done, load_done}), 8);
        rst_n = 1'b1;
        begin
            int n = 0;
            while (init_low && n < 100) begin
                n++;
                @(negedge clk);
            end
            chk(n == CC, "R1 clear length after reset", n, CC);
        end
        begin
            int edges = 0;
            logic pc = cclk;
            repeat (25) begin
                @(negedge clk);
                if (cclk != pc) edges++;
                pc = cclk;
            end
            chk(edges == 0 && !init_low, "R2 no clock while INIT held low", edges, 0);
        end
        hold = 1'b0;
        exp_h = FH;
        finish_load(1'b0);

        run_load(1'b1, 1'b1, 1'b1);
        run_load(1'b0, 1'b1, 1'b1);
        run_load(1'b1, 1'b0, 1'b0);

        // R9: abort mid-load then reload
        slow_sel = 1'b0;
        early_done = 1'b0;
        exp_h = FH;
        pulse_prog(8);
        begin
            int t = 0;
            while (rises < 13 && t < 2000) begin
                @(negedge clk);
                t++;
            end
            chk(rises == 13, "R9 partial load reached", rises, 13);
        end
        pulse_prog(10);
        chk(rises == 0 && got_n == 0, "R9 counts restart", rises, 0);
        finish_load(1'b0);

        for (int r = 0; r < 4; r++) begin
            run_load(1'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule